// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital sequencer of a 10-bit successive approximation analog-to-digital converter. An external digital-to-analog converter is driven from the trial word, and an external comparator answers whether that analog level lies above the sampled input. Each conversion begins with a start pulse. When the pulse ends, the block resolves one bit per bit period, working from the most significant bit downward, and leaves the final code in its result register. The code stays there until the next start.

Time is counted in bit periods of `BIT_CLKS` system clocks. The comparator answer passes through a two-flop synchronizer before the block uses it. A start pulse counts only after it has stayed high for `MIN_START_CLKS` clocks. A short-cycle mode resolves only the upper eight bits. While a conversion runs, the block sends each resolved bit out serially and gives a sync strobe that rises in the middle of every serial bit. Three-state pins are modelled as a value plus an output enable. Separate enables gate the high data byte, the low data byte and the status flag.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the status flag reads 1 (complete), the result word is 0, `clk_run_o` is 0, and the serial and sync enables are 0.
- R2: A start held high for at least `MIN_START_CLKS` consecutive clocks loads the trial word with 1 in bit 9 and 0 in bits 8..0. It also drives the status to 0, and the trial word keeps that value while start stays high. A shorter pulse changes neither the result nor the status.
- R3: Conversion begins at the first clock edge after start falls. Bit 9 is decided at the end of the second bit period, and each later bit one bit period after the one before it. The status returns to 1 one bit period after the last decision, which is (N_BITS+2)*BIT_CLKS clocks after that first edge in full mode. `clk_run_o` is high from the first edge until completion, and the status is never 1 while it is high.
- R4: The decision rule clears the trial bit when `cmp_i` is 1 (the DAC level is above the input) and keeps it at 1 otherwise, then tries the next lower bit. With an ideal comparator, every input code 0..1023 converts to itself in full mode. At most two trial bits change in any one clock outside a start load.
- R5: With `full_i` low when conversion begins, only bits 9..2 are decided and the conversion is 2 bit periods shorter. Bit 1 ends at 1 and bit 0 at 0. The mode is sampled only at the first conversion edge.
- R6: A qualified start during a conversion aborts it. The sequence restarts from bit 9 and converts the new input correctly.
- R7: `ser_o` presents each decided bit MSB first, one per bit period, in the period after its decision. `sync_o` rises once in the middle of each serial bit, and `ser_o` does not change on that edge. A full conversion gives 10 rising edges and a short conversion gives 8.
- R8: `ser_oe_o` and `sync_oe_o` are 0 whenever no conversion is running.
- R9: `hi_en_i` drives result bits 9..8 on `data_hi_o`, `lo_en_i` drives bits 7..0 on `data_lo_o`, and `stat_en_i` drives the status on `done_o`. Each output enable follows its enable input, and each value reads 0 while its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start request |
| cmp_i | input | 1 | Comparator answer, 1 when DAC level is above the input |
| full_i | input | 1 | 1 selects a full 10-bit conversion, 0 the 8-bit short cycle |
| hi_en_i | input | 1 | Enable for result bits 9..8 |
| lo_en_i | input | 1 | Enable for result bits 7..0 |
| stat_en_i | input | 1 | Enable for the status output |
| trial_o | output | 10 | Trial word to the external DAC |
| data_hi_o | output | 2 | Result bits 9..8 |
| data_hi_oe_o | output | 1 | Output enable of data_hi_o |
| data_lo_o | output | 8 | Result bits 7..0 |
| data_lo_oe_o | output | 1 | Output enable of data_lo_o |
| done_o | output | 1 | Status: 1 complete, 0 converting |
| done_oe_o | output | 1 | Output enable of done_o |
| ser_o | output | 1 | Serial NRZ result bits, MSB first |
| ser_oe_o | output | 1 | Output enable of ser_o |
| sync_o | output | 1 | Mid-bit strobe for ser_o |
| sync_oe_o | output | 1 | Output enable of sync_o |
| clk_run_o | output | 1 | High while a conversion sequence runs |

## Verification
Several properties are checked on every cycle. The trial word holds the MSB pattern while a qualified start is held. No more than two trial bits flip per clock during sequencing. The status and the run signal are never high together. A completed short conversion leaves the tail pattern 10 in bits 1..0. The serial data is stable on every rising sync edge. The exact code produced for each of the 1024 inputs in both modes can only be shown by the bench's scenarios. The same holds for the completion latency, the serial word and its edge count, the rejection of short start pulses, aborts in mid-conversion, and the sampling point of the mode select.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_CONV = 2'd2
    } sq_state_e;

    // Command from the sequencer to the trial register
    typedef struct packed {
        logic       load_top;   // preset to MSB-only trial word
        logic       decide;     // resolve bit idx and try idx-1
        logic [7:0] idx;        // bit being decided
    } trial_cmd_t;

    // Bit-period slot on which the conversion completes:
    // slot 0 lead-in, slots 1..k decisions, then one slot to complete.
    function automatic int unsigned final_slot(input int unsigned nbits,
                                               input int unsigned drop,
                                               input logic full);
        return full ? nbits + 1 : nbits + 1 - drop;
    endfunction

endpackage

// File: rtl/sar_cmp_sync.sv
module sar_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int N_BITS         = 10,
    parameter int SHORT_DROP     = 2,
    parameter int BIT_CLKS       = 4,
    parameter int MIN_START_CLKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       full_i,
    output trial_cmd_t cmd_o,
    output logic       run_o,
    output logic       hold_o,
    output logic       done_o,
    output logic       mode_full_o,
    output logic       window_o,
    output logic       sync_hi_o
);
    localparam int SLOT_W = $clog2(N_BITS + 2);
    localparam int PER_W  = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int HC_W   = $clog2(MIN_START_CLKS + 1);
    localparam logic [PER_W-1:0]  PER_LAST   = PER_W'(BIT_CLKS - 1);
    localparam logic [PER_W-1:0]  PER_MID    = PER_W'(BIT_CLKS / 2);
    localparam logic [SLOT_W-1:0] SLOT_FULL  = SLOT_W'(final_slot(N_BITS, SHORT_DROP, 1'b1));
    localparam logic [SLOT_W-1:0] SLOT_SHORT = SLOT_W'(final_slot(N_BITS, SHORT_DROP, 1'b0));
    localparam logic [SLOT_W-1:0] SLOT_OUT   = SLOT_W'(2);
    localparam logic [HC_W-1:0]   HC_ARM     = HC_W'(MIN_START_CLKS - 1);
    localparam logic [HC_W-1:0]   HC_SAT     = HC_W'(MIN_START_CLKS);

    sq_state_e          state_q;
    logic [HC_W-1:0]    hi_cnt_q;
    logic [PER_W-1:0]   per_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               done_q;
    logic               mode_q;

    logic               qualify;
    logic               conv;
    logic               tick;
    logic [SLOT_W-1:0]  last_slot;

    assign qualify   = start_i && (hi_cnt_q == HC_ARM);
    assign conv      = (state_q == SQ_CONV);
    assign tick      = conv && (per_q == PER_LAST);
    assign last_slot = mode_q ? SLOT_FULL : SLOT_SHORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            hi_cnt_q <= '0;
            per_q    <= '0;
            slot_q   <= '0;
            done_q   <= 1'b1;
            mode_q   <= 1'b1;
        end else begin
            // start qualification: consecutive high clocks, saturating
            if (!start_i)              hi_cnt_q <= '0;
            else if (hi_cnt_q != HC_SAT) hi_cnt_q <= hi_cnt_q + 1'b1;

            if (qualify) begin
                state_q <= SQ_HOLD;
                done_q  <= 1'b0;
            end else begin
                case (state_q)
                    SQ_HOLD: if (!start_i) begin
                        state_q <= SQ_CONV;
                        per_q   <= '0;
                        slot_q  <= '0;
                        mode_q  <= full_i;
                    end
                    SQ_CONV: if (tick) begin
                        per_q <= '0;
                        if (slot_q == last_slot) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end else begin
                        per_q <= per_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cmd_o.load_top = qualify;
        cmd_o.decide   = tick && (slot_q != '0) && (slot_q < last_slot);
        cmd_o.idx      = 8'(N_BITS) - 8'(slot_q);
    end

    assign run_o       = conv;
    assign hold_o      = (state_q == SQ_HOLD);
    assign done_o      = done_q;
    assign mode_full_o = mode_q;
    assign window_o    = conv && (slot_q >= SLOT_OUT);
    assign sync_hi_o   = window_o && (per_q >= PER_MID);

    // R3: completion flag and running sequence are exclusive
    p_done_run_r3: assert property (@(posedge clk) disable iff (rst)
        run_o |-> !done_q);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_pkg::*;
#(
    parameter int N_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  trial_cmd_t        cmd_i,
    input  logic              cmp_i,
    output logic [N_BITS-1:0] trial_o,
    output logic              ser_bit_o
);
    localparam logic [N_BITS-1:0] TOP_WORD = {1'b1, {(N_BITS-1){1'b0}}};

    logic [N_BITS-1:0] trial_q;
    logic [N_BITS-1:0] nxt;
    logic              ser_q;

    // Keep the trial bit unless the DAC level is above the input, then
    // try the next lower bit.
    always_comb begin
        nxt = trial_q;
        for (int b = 0; b < N_BITS; b++) begin
            if (b == int'(cmd_i.idx))          nxt[b] = ~cmp_i;
            else if (b + 1 == int'(cmd_i.idx)) nxt[b] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= '0;
            ser_q   <= 1'b0;
        end else if (cmd_i.load_top) begin
            trial_q <= TOP_WORD;
        end else if (cmd_i.decide) begin
            trial_q <= nxt;
            ser_q   <= ~cmp_i;
        end
    end

    assign trial_o   = trial_q;
    assign ser_bit_o = ser_q;

    // R4: a decision step touches at most the decided bit and the next trial
    p_step_bits_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_i.load_top) |-> ($countones(trial_q ^ $past(trial_q)) <= 2));

endmodule

// File: rtl/sar_pinmux.sv
module sar_pinmux #(
    parameter int N_BITS = 10,
    parameter int LO_W   = 8
) (
    input  logic              hi_en_i,
    input  logic              lo_en_i,
    input  logic              stat_en_i,
    input  logic [N_BITS-1:0] trial_i,
    input  logic              done_i,
    input  logic              run_i,
    input  logic              window_i,
    input  logic              sync_hi_i,
    input  logic              ser_bit_i,
    output logic [N_BITS-LO_W-1:0] data_hi_o,
    output logic              data_hi_oe_o,
    output logic [LO_W-1:0]   data_lo_o,
    output logic              data_lo_oe_o,
    output logic              done_o,
    output logic              done_oe_o,
    output logic              ser_o,
    output logic              ser_oe_o,
    output logic              sync_o,
    output logic              sync_oe_o
);
    assign data_hi_o    = hi_en_i ? trial_i[N_BITS-1:LO_W] : '0;
    assign data_hi_oe_o = hi_en_i;
    assign data_lo_o    = lo_en_i ? trial_i[LO_W-1:0] : '0;
    assign data_lo_oe_o = lo_en_i;
    assign done_o       = stat_en_i ? done_i : 1'b0;
    assign done_oe_o    = stat_en_i;
    assign ser_o        = window_i ? ser_bit_i : 1'b0;
    assign ser_oe_o     = run_i;
    assign sync_o       = sync_hi_i;
    assign sync_oe_o    = run_i;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int N_BITS         = 10,
    parameter int LO_W           = 8,
    parameter int SHORT_DROP     = 2,
    parameter int BIT_CLKS       = 4,
    parameter int MIN_START_CLKS = 3,
    parameter int SYNC_STAGES    = 2,
    localparam int HI_W          = N_BITS - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_i,
    input  logic              full_i,
    input  logic              hi_en_i,
    input  logic              lo_en_i,
    input  logic              stat_en_i,
    output logic [N_BITS-1:0] trial_o,
    output logic [HI_W-1:0]   data_hi_o,
    output logic              data_hi_oe_o,
    output logic [LO_W-1:0]   data_lo_o,
    output logic              data_lo_oe_o,
    output logic              done_o,
    output logic              done_oe_o,
    output logic              ser_o,
    output logic              ser_oe_o,
    output logic              sync_o,
    output logic              sync_oe_o,
    output logic              clk_run_o
);
    localparam logic [N_BITS-1:0] TOP_WORD  = {1'b1, {(N_BITS-1){1'b0}}};
    localparam logic [N_BITS-1:0] TAIL_MASK = N_BITS'((1 << SHORT_DROP) - 1);
    localparam logic [N_BITS-1:0] TAIL_VAL  = N_BITS'(1 << (SHORT_DROP - 1));

    trial_cmd_t cmd;
    logic       cmp_s;
    logic       run, hold, done, mode_full, window, sync_hi, ser_bit;
    logic [N_BITS-1:0] trial;

    sar_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(cmp_i), .q_o(cmp_s)
    );

    sar_sequencer #(
        .N_BITS(N_BITS), .SHORT_DROP(SHORT_DROP),
        .BIT_CLKS(BIT_CLKS), .MIN_START_CLKS(MIN_START_CLKS)
    ) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .full_i(full_i),
        .cmd_o(cmd), .run_o(run), .hold_o(hold), .done_o(done),
        .mode_full_o(mode_full), .window_o(window), .sync_hi_o(sync_hi)
    );

    sar_trial_reg #(.N_BITS(N_BITS)) u_trial (
        .clk(clk), .rst(rst), .cmd_i(cmd), .cmp_i(cmp_s),
        .trial_o(trial), .ser_bit_o(ser_bit)
    );

    sar_pinmux #(.N_BITS(N_BITS), .LO_W(LO_W)) u_pins (
        .hi_en_i(hi_en_i), .lo_en_i(lo_en_i), .stat_en_i(stat_en_i),
        .trial_i(trial), .done_i(done), .run_i(run), .window_i(window),
        .sync_hi_i(sync_hi), .ser_bit_i(ser_bit),
        .data_hi_o(data_hi_o), .data_hi_oe_o(data_hi_oe_o),
        .data_lo_o(data_lo_o), .data_lo_oe_o(data_lo_oe_o),
        .done_o(done_o), .done_oe_o(done_oe_o),
        .ser_o(ser_o), .ser_oe_o(ser_oe_o),
        .sync_o(sync_o), .sync_oe_o(sync_oe_o)
    );

    assign trial_o   = trial;
    assign clk_run_o = run;

    // R2: while a qualified start is held, the trial word is MSB only
    p_msb_hold_r2: assert property (@(posedge clk) disable iff (rst)
        hold |-> (trial == TOP_WORD));

    // R5: an idle result after a short conversion carries the fixed tail
    p_short_tail_r5: assert property (@(posedge clk) disable iff (rst)
        (!run && !hold && !mode_full) |-> ((trial & TAIL_MASK) == TAIL_VAL));

    // R7: serial data is steady where the sync strobe rises
    p_mid_edge_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> $stable(ser_o));

endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    localparam int N        = 10;
    localparam int DIV      = 4;
    localparam int MINST    = 3;
    localparam int LAT_FULL = (N + 2) * DIV + 1;
    localparam int LAT_SHRT = N * DIV + 1;
    localparam int NVEC     = 8;

    // {full, code}
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 10'd0},   {1'b1, 10'd1023}, {1'b1, 10'h200}, {1'b1, 10'h1FF},
        {1'b1, 10'h2AA}, {1'b0, 10'd0},    {1'b0, 10'd1023}, {1'b0, 10'h155}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, full = 1'b1;
    logic hi_en = 1'b1, lo_en = 1'b1, st_en = 1'b1;
    logic [N-1:0] code = '0;
    logic cmp;

    logic [N-1:0] trial;
    logic [1:0]   dhi;
    logic [7:0]   dlo;
    logic dhi_oe, dlo_oe, done, done_oe, ser, ser_oe, sync, sync_oe, crun;

    int checks = 0;
    int fails  = 0;
    int lat;
    int ser_cnt;
    logic [N-1:0] ser_word;
    bit finished = 0;

    always #5 clk = ~clk;

    // ideal comparator: 1 when the DAC level is above the input
    assign cmp = (trial > code);

    sar_seq_ctrl u0 (
        .clk(clk), .rst(rst), .start_i(start), .cmp_i(cmp), .full_i(full),
        .hi_en_i(hi_en), .lo_en_i(lo_en), .stat_en_i(st_en),
        .trial_o(trial), .data_hi_o(dhi), .data_hi_oe_o(dhi_oe),
        .data_lo_o(dlo), .data_lo_oe_o(dlo_oe), .done_o(done),
        .done_oe_o(done_oe), .ser_o(ser), .ser_oe_o(ser_oe),
        .sync_o(sync), .sync_oe_o(sync_oe), .clk_run_o(crun)
    );

    function automatic logic [N-1:0] expect_code(input logic [N-1:0] c, input logic f);
        return f ? c : {c[N-1:2], 2'b10};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int n);
        start = 1'b1;
        repeat (n) @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        logic prev;
        prev = 1'b0; lat = 0; ser_cnt = 0; ser_word = '0;
        do begin
            @(negedge clk);
            lat++;
            if (sync_oe && sync && !prev) begin
                ser_word = {ser_word[N-2:0], ser};
                ser_cnt++;
            end
            prev = sync;
        end while (!done && lat < 400);
    endtask

    task automatic run_conv(input logic [N-1:0] c, input logic f);
        @(negedge clk);
        code = c; full = f;
        pulse_start(MINST);
        wait_done();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 status", {31'd0, done}, 1);
        check("R1 result", {dhi, dlo}, 0);
        check("R1 clk_run", {31'd0, crun}, 0);
        check("R1 ser/sync oe", {ser_oe, sync_oe}, 0);

        // table of vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [N-1:0] c;
            logic f;
            {f, c} = VEC[i];
            run_conv(c, f);
            check("R4/R5 result", {dhi, dlo}, expect_code(c, f));
            check("R3/R5 latency", lat, f ? LAT_FULL : LAT_SHRT);
            check("R7 sync edges", ser_cnt, f ? N : N - 2);
            check("R7 serial word", ser_word, f ? c : {2'b00, c[N-1:2]});
            check("R8 float after", {crun, ser_oe, sync_oe}, 0);
        end

        // R2: qualified start held high shows MSB-only trial and busy status
        @(negedge clk);
        code = 10'h0C3; full = 1'b1;
        start = 1'b1;
        repeat (MINST + 2) @(negedge clk);
        check("R2 held trial", {dhi, dlo}, 10'h200);
        check("R2 status busy", {31'd0, done}, 0);
        check("R8 float while held", {ser_oe, sync_oe}, 0);
        start = 1'b0;
        wait_done();
        check("R2 result after hold", {dhi, dlo}, 10'h0C3);

        // R2: a pulse one clock too short is ignored
        run_conv(10'h123, 1'b1);
        @(negedge clk);
        pulse_start(MINST - 1);
        repeat (10) @(negedge clk);
        check("R2 short pulse result", {dhi, dlo}, 10'h123);
        check("R2 short pulse status", {31'd0, done}, 1);
        check("R2 short pulse run", {31'd0, crun}, 0);

        // R6: abort in mid-conversion and restart
        @(negedge clk);
        code = 10'h0F0; full = 1'b1;
        pulse_start(MINST);
        repeat (20) @(negedge clk);
        check("R3 running mid-conv", {31'd0, crun}, 1);
        code = 10'h3C5;
        pulse_start(MINST);
        wait_done();
        check("R6 restart result", {dhi, dlo}, 10'h3C5);
        check("R6 restart latency", lat, LAT_FULL);

        // R5: mode is taken only when conversion begins
        @(negedge clk);
        code = 10'h2E7; full = 1'b1;
        pulse_start(MINST);
        @(negedge clk);
        full = 1'b0;
        wait_done();
        check("R5 mode sample result", {dhi, dlo}, 10'h2E7);
        check("R5 mode sample latency", lat, LAT_FULL - 1);

        // R9: enable gating
        hi_en = 1'b0;
        @(negedge clk);
        check("R9 hi disabled", {dhi_oe, dhi}, 0);
        check("R9 lo enabled", {dlo_oe, dlo}, {1'b1, 8'hE7});
        hi_en = 1'b1; lo_en = 1'b0;
        @(negedge clk);
        check("R9 lo disabled", {dlo_oe, dlo}, 0);
        check("R9 hi enabled", {dhi_oe, dhi}, {1'b1, 2'b10});
        st_en = 1'b0;
        @(negedge clk);
        check("R9 status disabled", {done_oe, done}, 0);
        lo_en = 1'b1; st_en = 1'b1;
        @(negedge clk);
        check("R9 status enabled", {done_oe, done}, 2'b11);

        // exhaustive sweep, both modes
        for (int m = 1; m >= 0; m--) begin
            for (int c = 0; c < 1024; c++) begin
                run_conv(N'(c), m[0]);
                check(m ? "R4 sweep full" : "R5 sweep short",
                      {dhi, dlo}, expect_code(N'(c), m[0]));
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule